// File: doc/BRIEF.md
# SPI Slave Pause-and-Resume Front End

This block sits between the pins of an SPI slave and the command engine behind it. It oversamples the serial clock, data input, active-low select and active-low pause request with a fast system clock. It turns serial clock edges into single-cycle strobes for the engine: a receive strobe carries the sampled input bit, and a transmit strobe tells the engine to present its next output bit. It also keeps a bit position counter within the current word.

The pause request lets a host park a transfer in the middle of a word. The request only takes effect while the serial clock is low. If it arrives while the clock is high, it waits for the next falling edge. While paused, clock and data-in activity is ignored and the bit position is frozen. A pause is released the same way, only while the clock is low, so shifting continues at exactly the bit where it stopped. The output driver is disabled whenever the pause pin is low, during a pause and while deselected. Deselecting the block clears both the pause and the bit position.

Top module: `spi_hold_front`

## Requirements
- R1: After reset, `paused`, `bit_strobe`, `shift_strobe`, `rx_bit`, `so_oe` and `bit_idx` are all 0.
- R2: Each pin passes through a two-flop synchronizer. A rising SCK edge seen while selected and not paused gives a one-cycle `bit_strobe` 3 clock cycles after the pin edge, with `rx_bit` holding the synchronized SI level sampled at that edge.
- R3: When the pause pin goes low while SCK is low and the block is selected, `paused` rises 3 cycles later.
- R4: When the pause pin goes low while SCK is high, `paused` stays 0 until SCK falls. It rises 3 cycles after that falling edge.
- R5: While `paused` is 1, SCK and SI activity produces no `bit_strobe` and no `shift_strobe`, and `bit_idx` and `rx_bit` keep their values.
- R6: A pause ends only when the pause pin is high while SCK is low. A release made while SCK is high waits for the next SCK falling edge.
- R7: `so_oe` is 1 only when the block is selected, the synchronized pause pin is high and the block is not paused. `so_data` equals `tx_bit` when `so_oe` is 1 and is 0 otherwise.
- R8: Select going high (deselect) clears `paused` and resets `bit_idx` to 0, even in the middle of a pause.
- R9: `bit_idx` counts receive strobes modulo WORD_BITS (8 by default). A falling SCK edge while selected and not paused gives a one-cycle `shift_strobe`.
- R10: While deselected, SCK edges produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data input pin |
| cs_n | input | 1 | Active-low select pin |
| hold_n | input | 1 | Active-low pause request pin |
| tx_bit | input | 1 | Next output bit from the command engine |
| bit_strobe | output | 1 | One-cycle pulse per accepted rising SCK edge |
| rx_bit | output | 1 | SI bit captured at the last accepted rising edge |
| shift_strobe | output | 1 | One-cycle pulse per accepted falling SCK edge |
| bit_idx | output | $clog2(WORD_BITS) | Bit position within the current word |
| paused | output | 1 | Transfer is parked |
| so_oe | output | 1 | Output driver enable |
| so_data | output | 1 | Gated output bit |

## Verification
The hardest situations to reach are a pause requested or released while SCK is high, because the effect has to be held back until a later falling edge. The stimulus parks SCK high, moves the pause pin, and waits several cycles before SCK is lowered. Directed checks confirm that nothing changed in between. SCK and SI are toggled during a pause so that a frozen bit position can be told apart from one that kept counting. A per-cycle reference model checks every output throughout, including a deselect in the middle of a pause.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    localparam int NUM_PINS = 4;
    typedef enum int {
        PIN_SCK  = 0,
        PIN_SI   = 1,
        PIN_CS   = 2,
        PIN_HOLD = 3
    } pin_e;
    // idle levels: clock low, data low, deselected, no pause request
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b1100;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= IDLE;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= IDLE;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/fe_hold_ctl.sv
module fe_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck_lvl,
    input  logic hold_lvl,
    output logic paused_q,
    output logic paused_d
);
    // entry and exit are only allowed while the serial clock is low
    always_comb begin
        paused_d = paused_q;
        if (!sel) begin
            paused_d = 1'b0;
        end else if (!paused_q && !hold_lvl && !sck_lvl) begin
            paused_d = 1'b1;
        end else if (paused_q && hold_lvl && !sck_lvl) begin
            paused_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) paused_q <= 1'b0;
        else        paused_q <= paused_d;
    end
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front #(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_BITS = 8,
    localparam int IDX_W = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             si,
    input  logic             cs_n,
    input  logic             hold_n,
    input  logic             tx_bit,
    output logic             bit_strobe,
    output logic             rx_bit,
    output logic             shift_strobe,
    output logic [IDX_W-1:0] bit_idx,
    output logic             paused,
    output logic             so_oe,
    output logic             so_data
);
    import spi_hold_pkg::*;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BITS - 1);

    typedef struct packed {
        logic             sck_prev;
        logic             bit_strobe;
        logic             shift_strobe;
        logic             rx_bit;
        logic             so_oe;
        logic [IDX_W-1:0] idx;
    } fe_state_t;

    fe_state_t st_d, st_q;

    logic [NUM_PINS-1:0] pins_raw, pins_s;
    logic sck_lvl, si_lvl, sel, hold_lvl;
    logic paused_q, paused_d;
    logic rise, fall, take_bit;

    assign pins_raw[PIN_SCK]  = sck;
    assign pins_raw[PIN_SI]   = si;
    assign pins_raw[PIN_CS]   = cs_n;
    assign pins_raw[PIN_HOLD] = hold_n;

    fe_sync #(
        .WIDTH (NUM_PINS),
        .STAGES(SYNC_STAGES),
        .IDLE  (PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign sck_lvl  = pins_s[PIN_SCK];
    assign si_lvl   = pins_s[PIN_SI];
    assign sel      = !pins_s[PIN_CS];
    assign hold_lvl = pins_s[PIN_HOLD];

    fe_hold_ctl u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .sck_lvl (sck_lvl),
        .hold_lvl(hold_lvl),
        .paused_q(paused_q),
        .paused_d(paused_d)
    );

    always_comb begin
        st_d          = st_q;
        rise          = sck_lvl && !st_q.sck_prev;
        fall          = !sck_lvl && st_q.sck_prev;
        take_bit      = rise && sel && !paused_q;
        st_d.sck_prev = sck_lvl;
        st_d.bit_strobe   = take_bit;
        st_d.shift_strobe = fall && sel && !paused_q;
        if (take_bit) begin
            st_d.rx_bit = si_lvl;
            st_d.idx    = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + 1'b1;
        end
        if (!sel) begin
            st_d.idx = '0;
        end
        st_d.so_oe = sel && hold_lvl && !paused_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_strobe   = st_q.bit_strobe;
    assign shift_strobe = st_q.shift_strobe;
    assign rx_bit       = st_q.rx_bit;
    assign bit_idx      = st_q.idx;
    assign paused       = paused_q;
    assign so_oe        = st_q.so_oe;
    assign so_data      = st_q.so_oe ? tx_bit : 1'b0;
endmodule

// File: rtl/spi_hold_front_chk.sv
module spi_hold_front_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_strobe,
    input logic             shift_strobe,
    input logic             rx_bit,
    input logic [IDX_W-1:0] bit_idx,
    input logic             paused,
    input logic             so_oe,
    input logic             so_data
);
    // R5
    paused_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> (!bit_strobe && !shift_strobe));
    // R5
    paused_idx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> ($stable(bit_idx) || bit_idx == '0));
    // R5
    paused_rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> $stable(rx_bit));
    // R7
    paused_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !so_oe);
    // R7
    idle_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> !so_data);
    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);
    // R9
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_strobe, shift_strobe}));
endmodule

bind spi_hold_front spi_hold_front_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_strobe  (bit_strobe),
    .shift_strobe(shift_strobe),
    .rx_bit      (rx_bit),
    .bit_idx     (bit_idx),
    .paused      (paused),
    .so_oe       (so_oe),
    .so_data     (so_data)
);

// File: tb/spi_hold_front_bench.sv
`timescale 1ns/1ps
module spi_hold_front_bench;
    localparam int WB = 8;
    localparam int IW = $clog2(WB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, tx_bit = 1'b0;
    logic bit_strobe, rx_bit, shift_strobe, paused, so_oe, so_data;
    logic [IW-1:0] bit_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_hold_front #(.SYNC_STAGES(2), .WORD_BITS(WB)) u_spi_hold_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
        .hold_n(hold_n), .tx_bit(tx_bit), .bit_strobe(bit_strobe),
        .rx_bit(rx_bit), .shift_strobe(shift_strobe), .bit_idx(bit_idx),
        .paused(paused), .so_oe(so_oe), .so_data(so_data)
    );

    // reference model: pin history delayed two samples, then per-cycle rules
    bit h_sck[2], h_si[2], h_cs[2], h_hold[2];
    bit m_prev, m_paused, m_bs, m_ss, m_rx, m_oe;
    int m_idx;

    always @(posedge clk) begin
        bit s_sck, s_si, s_sel, s_hold, up, down, np;
        if (!rst_n) begin
            h_sck = '{0, 0}; h_si = '{0, 0}; h_cs = '{1, 1}; h_hold = '{1, 1};
            m_prev = 0; m_paused = 0; m_bs = 0; m_ss = 0; m_rx = 0; m_oe = 0; m_idx = 0;
        end else begin
            s_sck = h_sck[1]; s_si = h_si[1]; s_sel = !h_cs[1]; s_hold = h_hold[1];
            up   = s_sck && !m_prev;
            down = !s_sck && m_prev;
            m_bs = up && s_sel && !m_paused;
            m_ss = down && s_sel && !m_paused;
            if (m_bs) begin
                m_rx  = s_si;
                m_idx = (m_idx + 1) % WB;
            end
            np = m_paused;
            if (!s_sel) np = 0;
            else if (!m_paused && !s_hold && !s_sck) np = 1;
            else if (m_paused && s_hold && !s_sck) np = 0;
            m_paused = np;
            if (!s_sel) m_idx = 0;
            m_oe = s_sel && s_hold && !np;
            m_prev = s_sck;
            h_sck[1] = h_sck[0]; h_si[1] = h_si[0]; h_cs[1] = h_cs[0]; h_hold[1] = h_hold[0];
            h_sck[0] = sck; h_si[0] = si; h_cs[0] = cs_n; h_hold[0] = hold_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 bit_strobe", bit_strobe, m_bs);
            chk("R2 rx_bit", rx_bit, m_rx);
            chk("R9 shift_strobe", shift_strobe, m_ss);
            chk("R5 bit_idx", bit_idx, m_idx);
            chk("R6 paused", paused, m_paused);
            chk("R7 so_oe", so_oe, m_oe);
            chk("R7 so_data", so_data, m_oe ? tx_bit : 1'b0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input bit v);
        si = v;
        wait_cyc(4);
        sck = 1'b1;
        wait_cyc(4);
        sck = 1'b0;
        tx_bit = ~tx_bit;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int strobes;
        wait_cyc(3);
        // R1 reset state
        chk("R1 paused", paused, 0);
        chk("R1 bit_strobe", bit_strobe, 0);
        chk("R1 so_oe", so_oe, 0);
        chk("R1 bit_idx", bit_idx, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10 clocks while deselected give no strobes
        strobes = 0;
        fork
            begin for (int i = 0; i < 3; i++) send_bit(1'b1); end
            begin repeat (30) begin @(negedge clk); strobes += bit_strobe + shift_strobe; end end
        join
        chk("R10 no strobes deselected", strobes, 0);

        // select and shift a full word
        cs_n = 1'b0;
        wait_cyc(5);
        for (int i = 0; i < 8; i++) send_bit(((8'hA5 >> (7 - i)) & 1) != 0);
        wait_cyc(5);
        chk("R9 wrap to zero", bit_idx, 0);

        // three bits then pause with SCK low
        for (int i = 0; i < 3; i++) send_bit(i[0]);
        wait_cyc(5);
        chk("R9 idx after three", bit_idx, 3);
        hold_n = 1'b0;
        wait_cyc(2);
        chk("R3 not yet paused", paused, 0);
        wait_cyc(1);
        chk("R3 paused after 3", paused, 1);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        wait_cyc(5);
        chk("R5 idx frozen", bit_idx, 3);
        chk("R7 oe off paused", so_oe, 0);

        // R6 release with SCK high waits for fall
        sck = 1'b1;
        wait_cyc(5);
        hold_n = 1'b1;
        wait_cyc(6);
        chk("R6 still paused", paused, 1);
        sck = 1'b0;
        wait_cyc(5);
        chk("R6 resumed", paused, 0);
        for (int i = 0; i < 2; i++) send_bit(1'b0);
        wait_cyc(5);
        chk("R5 resume position", bit_idx, 5);

        // R4 request with SCK high waits for fall
        sck = 1'b1;
        wait_cyc(5);
        hold_n = 1'b0;
        wait_cyc(6);
        chk("R4 not paused while high", paused, 0);
        chk("R7 oe off hold low", so_oe, 0);
        sck = 1'b0;
        wait_cyc(5);
        chk("R4 paused after fall", paused, 1);

        // R8 deselect during pause
        cs_n = 1'b1;
        wait_cyc(5);
        chk("R8 pause cleared", paused, 0);
        chk("R8 idx cleared", bit_idx, 0);
        hold_n = 1'b1;
        cs_n = 1'b0;
        wait_cyc(5);
        send_bit(1'b1);
        wait_cyc(5);
        chk("R2 rx after reselect", rx_bit, 1);
        chk("R9 idx after reselect", bit_idx, 1);
        cs_n = 1'b1;
        wait_cyc(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule